// File: doc/BRIEF.md
# PDM Decimating CIC Filter

This block turns a one-bit pulse-density-modulated stream from a digital microphone into multi-bit samples. The stream is sampled once per system clock and fed to a cascaded integrator-comb filter with two integrator stages and two comb stages. The filter decimates by four and yields a 6-bit unsigned sample. For every input bit it also produces a strobe clock at a quarter of the system rate, so that an external receiver can latch each sample. A copy of the system clock is driven out to clock the microphone itself.

The input bit is read as an unsigned value of 0 or 1, so a constant stream of ones settles at the filter's full gain of 16. The integrators wrap around in two's complement, and the wrap cancels in the combs, so the block runs on any stream without overflow handling. The asynchronous reset takes effect at once. Its release passes through a two-stage synchronizer.

Top module: `pdm_cic_decim`

## Requirements
- R1: The PDM bit on `pdm_i` is taken on every rising clock edge. Active edge 1 is the third rising edge after `rst_n` goes high, and edges are counted from there. x[k] is the bit taken at active edge k, and x[k] is 0 for k below 1.
- R2: At each active edge k that is a multiple of 4, `sample_o` takes the value x[k-2] + 2x[k-3] + 3x[k-4] + 4x[k-5] + 3x[k-6] + 2x[k-7] + x[k-8], as an unsigned number from 0 to 16 on bits 5:0.
- R3: A stream of ones of any length, including runs far longer than the integrators can count, keeps giving 16 once the filter has settled.
- R4: `samp_clk_o` is low for two clock periods and high for two. After active edge k it is high exactly when k mod 4 is 2 or 3.
- R5: `sample_o` changes only at the edge where `samp_clk_o` falls. It is stable while `samp_clk_o` is high.
- R6: `mic_clk_o` follows `clk`: high while the clock is high, low while it is low.
- R7: While `rst_n` is low, `sample_o` and `samp_clk_o` are 0 at once, without waiting for a clock edge. A reset in mid-run clears all filter history, so the following samples follow R2 with the new edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, equal to the PDM bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_i | input | 1 | One-bit PDM data from the microphone |
| sample_o | output | 6 | Filtered, decimated sample |
| samp_clk_o | output | 1 | Sample strobe clock at one quarter of the clock rate |
| mic_clk_o | output | 1 | Pass-through of the system clock for the microphone |

## Verification
The bench works out every expected sample from the seven-tap triangular weighting of its own record of input bits. A design with the wrong stage order, a missing pipeline register or a misplaced decimation phase would show up as impulse and alternating-pattern samples shifted by a clock or weighted wrongly. A run of ones hundreds of cycles long targets integrator wrap: a design that saturates or takes too narrow a comb would drift off 16. A reset while the strobe is high checks that both outputs clear without a clock edge. It also checks that stale comb delays do not leak into the first samples after restart. The strobe phase and the sample-hold window are checked on every clock, so a sample register that updates at the rising edge of the strobe would be caught at once.

// File: rtl/pdm_cic_pkg.sv
package pdm_cic_pkg;

  // Accumulator width that holds the full CIC gain DECIM**STAGES
  // (differential delay 1) without loss after comb cancellation.
  function automatic int acc_width(input int stages, input int decim);
    return stages * $clog2(decim) + 1;
  endfunction

endpackage

// File: rtl/pdm_cic_integ.sv
module pdm_cic_integ #(
  parameter int STAGES = 2,
  parameter int ACC_W  = 5
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             pdm_i,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] acc_q [STAGES];
  logic [ACC_W-1:0] acc_d [STAGES];
  logic [ACC_W-1:0] feed  [STAGES];

  assign feed[0] = {{(ACC_W-1){1'b0}}, pdm_i};

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_feed
      assign feed[s] = acc_q[s-1];
    end

    for (s = 0; s < STAGES; s++) begin : g_stage
      always_comb begin
        acc_d[s] = acc_q[s] + feed[s];
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) acc_q[s] <= '0;
        else         acc_q[s] <= acc_d[s];
      end
    end
  endgenerate

  assign acc_o = acc_q[STAGES-1];

endmodule

// File: rtl/pdm_cic_phase.sv
module pdm_cic_phase #(
  parameter int DECIM = 4
) (
  input  logic clk,
  input  logic rst_ni,
  output logic dec_en_o,
  output logic strobe_o
);

  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DECIM - 1);
  localparam logic [PH_W-1:0] HALF = PH_W'(DECIM / 2);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;
  logic            strobe_q;
  logic            strobe_d;

  always_comb begin
    if (ph_q == LAST) ph_d = '0;
    else              ph_d = ph_q + 1'b1;
    strobe_d = (ph_d >= HALF);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= '0;
      strobe_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      strobe_q <= strobe_d;
    end
  end

  assign dec_en_o = (ph_q == LAST);
  assign strobe_o = strobe_q;

endmodule

// File: rtl/pdm_cic_comb.sv
module pdm_cic_comb #(
  parameter int STAGES = 2,
  parameter int ACC_W  = 5
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             dec_en_i,
  input  logic [ACC_W-1:0] din_i,
  output logic [ACC_W-1:0] dout_o
);

  logic [ACC_W-1:0] dly_q [STAGES];
  logic [ACC_W-1:0] dly_d [STAGES];
  logic [ACC_W-1:0] tap   [STAGES+1];
  logic [ACC_W-1:0] out_q;
  logic [ACC_W-1:0] out_d;

  assign tap[0] = din_i;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      assign tap[s+1] = tap[s] - dly_q[s];

      always_comb begin
        dly_d[s] = dly_q[s];
        if (dec_en_i) dly_d[s] = tap[s];
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) dly_q[s] <= '0;
        else         dly_q[s] <= dly_d[s];
      end
    end
  endgenerate

  always_comb begin
    out_d = out_q;
    if (dec_en_i) out_d = tap[STAGES];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign dout_o = out_q;

endmodule

// File: rtl/pdm_cic_decim.sv
module pdm_cic_decim #(
  parameter int STAGES = 2,
  parameter int DECIM  = 4,
  parameter int OUT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdm_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             samp_clk_o,
  output logic             mic_clk_o
);

  localparam int ACC_W = pdm_cic_pkg::acc_width(STAGES, DECIM);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [ACC_W-1:0] integ_out;
  logic [ACC_W-1:0] comb_out;
  logic             dec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  pdm_cic_integ #(.STAGES(STAGES), .ACC_W(ACC_W)) u_integ (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .pdm_i  (pdm_i),
    .acc_o  (integ_out)
  );

  pdm_cic_phase #(.DECIM(DECIM)) u_phase (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .dec_en_o (dec_en),
    .strobe_o (samp_clk_o)
  );

  pdm_cic_comb #(.STAGES(STAGES), .ACC_W(ACC_W)) u_comb (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .dec_en_i (dec_en),
    .din_i    (integ_out),
    .dout_o   (comb_out)
  );

  generate
    if (OUT_W >= ACC_W) begin : g_widen
      assign sample_o = {{(OUT_W-ACC_W){1'b0}}, comb_out};
    end else begin : g_narrow
      assign sample_o = comb_out[ACC_W-1 -: OUT_W];
    end
  endgenerate

  assign mic_clk_o = clk;

endmodule

// File: rtl/pdm_cic_chk.sv
module pdm_cic_chk #(
  parameter int STAGES = 2,
  parameter int DECIM  = 4,
  parameter int OUT_W  = 6
) (
  input logic             clk,
  input logic             rst_ni,
  input logic [OUT_W-1:0] samp,
  input logic             strobe
);

  localparam int GAIN = DECIM ** STAGES;

  assert_sample_range_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    int'(samp) <= GAIN);

  assert_strobe_rise_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(strobe) |=> $stable(strobe));

  assert_strobe_fall_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(strobe) |=> $stable(strobe));

  assert_update_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(samp) |-> $fell(strobe));

  assert_hold_while_high_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    strobe |-> $stable(samp));

endmodule

bind pdm_cic_decim pdm_cic_chk #(.STAGES(STAGES), .DECIM(DECIM), .OUT_W(OUT_W)) u_chk (
  .clk    (clk),
  .rst_ni (rst_int_n),
  .samp   (sample_o),
  .strobe (samp_clk_o)
);

// File: tb/sim_pdm_cic_decim.sv
module sim_pdm_cic_decim;

  localparam int CLK_P = 10;
  localparam int HIST  = 4096;

  logic       clk;
  logic       rst_n;
  logic       pdm_i;
  logic [5:0] sample_o;
  logic       samp_clk_o;
  logic       mic_clk_o;

  int   n_chk;
  int   n_bad;
  int   k;
  int   exp_s;
  bit   hist [HIST];
  logic [15:0] lfsr;

  pdm_cic_decim u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdm_i      (pdm_i),
    .sample_o   (sample_o),
    .samp_clk_o (samp_clk_o),
    .mic_clk_o  (mic_clk_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, expv, k);
    end
  endtask

  function automatic int xbit(input int idx);
    if (idx < 1) return 0;
    return int'(hist[idx]);
  endfunction

  function automatic int model(input int kk);
    int w[7] = '{1, 2, 3, 4, 3, 2, 1};
    int acc = 0;
    for (int m = 0; m < 7; m++) acc += w[m] * xbit(kk - 2 - m);
    return acc;
  endfunction

  // One active edge: drive at negedge, check at the following negedge.
  task automatic step(input logic b, input string req);
    pdm_i = b;
    @(posedge clk);
    k++;
    hist[k] = b;
    if (k % 4 == 0) exp_s = model(k);
    @(negedge clk);
    chk({req, "/R2"}, int'(sample_o), exp_s);
    chk("R4 strobe phase", int'(samp_clk_o), ((k % 4) >= 2) ? 1 : 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pdm_i = 1'b0;
    #1;
    chk("R7 async sample clear", int'(sample_o), 0);
    chk("R7 async strobe clear", int'(samp_clk_o), 0);
    repeat (2) @(negedge clk);
    chk("R7 sample held in reset", int'(sample_o), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    k = 0;
    exp_s = 0;
    for (int i = 0; i < HIST; i++) hist[i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_zeros();
    for (int i = 0; i < 40; i++) step(1'b0, "R1 zeros");
    chk("R2 zero stream", int'(sample_o), 0);
  endtask

  task automatic t_impulse();
    step(1'b1, "R1 impulse");
    for (int i = 0; i < 31; i++) step(1'b0, "R1 impulse tail");
    chk("R2 impulse settles", int'(sample_o), 0);
  endtask

  task automatic t_ones();
    for (int i = 0; i < 300; i++) step(1'b1, "R3 long ones");
    chk("R3 full scale after wrap", int'(sample_o), 16);
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 64; i++) step(i[0], "R2 alternating");
  endtask

  task automatic t_quarter();
    for (int i = 0; i < 64; i++) step((i % 4) == 1, "R2 quarter density");
    chk("R2 quarter density steady", int'(sample_o), 4);
  endtask

  task automatic t_lfsr();
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], "R2 pseudo-random");
    end
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 22; i++) step(1'b1, "R7 pre-reset");
    chk("R7 strobe high before reset", int'(samp_clk_o), 1);
    do_reset();
    for (int i = 0; i < 12; i++) step(1'b1, "R7 after reset");
  endtask

  task automatic t_mic();
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      #1;
      chk("R6 mic clock high", int'(mic_clk_o), 1);
      @(negedge clk);
      #1;
      chk("R6 mic clock low", int'(mic_clk_o), 0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    k     = 0;
    exp_s = 0;
    lfsr  = 16'hACE1;
    rst_n = 1'b0;
    pdm_i = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();
    t_zeros();
    t_impulse();
    t_alternate();
    t_quarter();
    t_ones();
    t_lfsr();
    t_midreset();
    t_mic();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule